// File: doc/BRIEF.md
# Change-of-State Input Interrupt Gate

A small register-mapped input block that watches a vector of digital inputs and raises a single interrupt whenever any input changes level. Each input passes through a two-flop synchronizer. A change is found by comparing the synchronized vector with its value one cycle earlier. No line can be masked on its own: any difference on any bit counts as an event.

Interrupt control works through the kind of bus access, not through data bits. A read of the control offset enables interrupts. A write to the same offset disables them. A write to the clear offset drops a pending interrupt. The write data is ignored in every one of these cases. The event is latched, and a status offset reports whether it has been latched. Software can also read back the synchronized input levels one byte at a time.

Top module: `chg_irq_gate`

## Requirements
- R1: While interrupts are enabled, a level change on any bit of `in_i` latches a pending event and drives `irq_o` high. `irq_o` rises after the third rising clock edge that follows the input change: two synchronizer flops, then the latch.
- R2: A read strobe at offset 0x2 enables interrupts. A write strobe at offset 0x2 disables them. The value on `wdata_i` has no effect on either action.
- R3: A write to offset 0x2 drives `irq_o` low from the next cycle. A pending event stays latched, so status bit 2 still reads 1.
- R4: A write to offset 0x1 clears a pending event, whatever the data. If a new change is detected in the same cycle as the clear, the new event wins and the pending event stays set.
- R5: Changes detected while interrupts are disabled are not latched. Enabling interrupts afterwards does not raise `irq_o`.
- R6: A latched event keeps `irq_o` high until it is cleared, even after the inputs return to their earlier levels.
- R7: A read of offset 0x6 returns the pending event in bit 2 and zero in every other bit. Read data appears on `rdata_o` after the clock edge that samples the read strobe, and it is held until the next read.
- R8: A read of offset 0x4 returns synchronized inputs 7..0. A read of offset 0x5 returns synchronized inputs 15..8.
- R9: After reset, interrupts are disabled, no event is pending, `irq_o` is low and `rdata_o` is zero.
- R10: A read of any other offset returns zero. A write to any other offset changes neither the enable nor the pending event.
- R11: If interrupts are re-enabled while an event is still pending, `irq_o` goes high again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Bus offset |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data, ignored by every control offset |
| rdata_o | output | 8 | Registered read data |
| in_i | input | 16 | Asynchronous digital inputs |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
If the enable flop held the wrong value, it would show at the ports within one cycle. Either `irq_o` would stay low three edges after an input toggle, or it would rise when no change was allowed. A pending event that was lost or stuck shows at once in bit 2 of the status read and in `irq_o`, including the case where the inputs flip back. A fault in the synchronizer or the compare stage shows as a shift in the three-edge latency, or as an input byte that reads back wrong two edges after it is driven.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  // Offsets whose access type carries meaning
  localparam int unsigned OFF_CLR  = 32'h1;
  localparam int unsigned OFF_CTL  = 32'h2;
  localparam int unsigned OFF_IN   = 32'h4;
  localparam int unsigned OFF_STAT = 32'h6;
  localparam int unsigned STAT_BIT = 2;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic pend_clr;
  } ctl_cmd_t;
endpackage

// File: rtl/chg_irq_sync.sv
module chg_irq_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= '0;
          else         stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/chg_irq_detect.sv
module chg_irq_detect #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] cur_i,
  output logic             change_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  assign change_o = |(cur_i ^ prev_q);
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import chg_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ctl_cmd_t cmd_i,
  input  logic     change_i,
  output logic     en_o,
  output logic     pend_o
);
  logic en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (cmd_i.en_clr) begin
      en_q <= 1'b0;
    end else if (cmd_i.en_set) begin
      en_q <= 1'b1;
    end
  end

  // A fresh event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (change_i && en_q) begin
      pend_q <= 1'b1;
    end else if (cmd_i.pend_clr) begin
      pend_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/chg_irq_regs.sv
module chg_irq_regs
  import chg_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_IN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [NUM_IN-1:0] in_sync_i,
  input  logic              pend_i,
  output ctl_cmd_t          cmd_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned NUM_BYTES = NUM_IN / DATA_W;

  logic [DATA_W-1:0] rmux;
  logic [DATA_W-1:0] rdata_q;
  logic [NUM_BYTES-1:0][DATA_W-1:0] in_bytes;

  generate
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      assign in_bytes[b] = in_sync_i[b*DATA_W +: DATA_W];
    end
  endgenerate

  assign cmd_o.en_set   = rd_i && (addr_i == ADDR_W'(OFF_CTL));
  assign cmd_o.en_clr   = wr_i && (addr_i == ADDR_W'(OFF_CTL));
  assign cmd_o.pend_clr = wr_i && (addr_i == ADDR_W'(OFF_CLR));

  always_comb begin
    rmux = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (addr_i == ADDR_W'(OFF_IN + b)) rmux = in_bytes[b];
    end
    if (addr_i == ADDR_W'(OFF_STAT)) rmux[STAT_BIT] = pend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/chg_irq_gate.sv
module chg_irq_gate
  import chg_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_IN      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_IN-1:0] in_i,
  output logic              irq_o
);
  logic [NUM_IN-1:0] in_sync;
  logic              change;
  logic              irq_en;
  logic              pending;
  ctl_cmd_t          cmd;
  logic              unused_wdata;

  // Control is by access type only
  assign unused_wdata = ^wdata_i;

  chg_irq_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(in_i), .q_o(in_sync)
  );

  chg_irq_detect #(.WIDTH(NUM_IN)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(in_sync), .change_o(change)
  );

  chg_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IN(NUM_IN)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .in_sync_i(in_sync), .pend_i(pending), .cmd_o(cmd), .rdata_o(rdata_o)
  );

  chg_irq_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .change_i(change),
    .en_o(irq_en), .pend_o(pending)
  );

  assign irq_o = pending & irq_en;
endmodule

// File: rtl/chg_irq_gate_chk.sv
module chg_irq_gate_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              change_i,
  input logic              en_i,
  input logic              pend_i,
  input logic              irq_o
);
  // R1
  latch_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change_i && en_i) |=> pend_i);

  // R3
  disable_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(2)) |=> !irq_o);

  // R4
  clear_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(1) && !change_i) |=> !pend_i);

  // R5
  no_latch_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !pend_i) |=> !pend_i);

  // R6
  pending_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !(wr_i && addr_i == ADDR_W'(1))) |=> pend_i);

  // R7
  status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(6)) |=> (rdata_o == (DATA_W'($past(pend_i)) << 2)));

  // R2
  read_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == ADDR_W'(2)) |=> en_i);
endmodule

bind chg_irq_gate chg_irq_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .rdata_o(rdata_o), .change_i(change), .en_i(irq_en), .pend_i(pending),
  .irq_o(irq_o)
);

// File: tb/tb_chg_irq_gate.sv
module tb_chg_irq_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [15:0] in_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  chg_irq_gate dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .in_i(in_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk_i); addr_i = a; wdata_i = v; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_in(input logic [15:0] v);
    @(negedge clk_i); in_i = v;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R9 irq", {15'b0, irq_o}, 16'h0);
    check("R9 rdata", {8'h0, rdata_o}, 16'h0);
    bus_rd(4'h6, d);
    check("R9 status", {8'h0, d}, 16'h0);
  endtask

  task automatic t_disabled_ignored;
    logic [7:0] d;
    set_in(16'h0081); idle(5);
    check("R5 irq while disabled", {15'b0, irq_o}, 16'h0);
    bus_rd(4'h2, d); idle(2);
    check("R5 irq after late enable", {15'b0, irq_o}, 16'h0);
    bus_rd(4'h6, d);
    check("R5 status", {8'h0, d}, 16'h0);
  endtask

  task automatic t_latency;
    // in changes at negedge; edges 1,2 sync, edge 3 latch
    set_in(16'h0080);
    @(posedge clk_i); @(posedge clk_i); #1;
    check("R1 not yet after 2 edges", {15'b0, irq_o}, 16'h0);
    @(posedge clk_i); #1;
    check("R1 irq after 3 edges", {15'b0, irq_o}, 16'h1);
  endtask

  task automatic t_hold_and_clear;
    logic [7:0] d;
    set_in(16'h0081); idle(6);
    check("R6 irq held after revert", {15'b0, irq_o}, 16'h1);
    bus_rd(4'h6, d);
    check("R7 status set", {8'h0, d}, 16'h0004);
    bus_wr(4'h3, 8'hFF); bus_wr(4'h7, 8'h00);
    check("R10 other writes", {15'b0, irq_o}, 16'h1);
    bus_wr(4'h1, 8'h00);
    check("R4 cleared", {15'b0, irq_o}, 16'h0);
    bus_rd(4'h6, d);
    check("R4 status cleared", {8'h0, d}, 16'h0);
  endtask

  task automatic t_disable_keep_status;
    logic [7:0] d;
    set_in(16'h8081); idle(5);
    check("R1 high bit change", {15'b0, irq_o}, 16'h1);
    bus_wr(4'h2, 8'hFF);
    check("R3 irq low after disable", {15'b0, irq_o}, 16'h0);
    bus_rd(4'h6, d);
    check("R3 status kept", {8'h0, d}, 16'h0004);
    bus_rd(4'h2, d);
    check("R11 reassert on enable", {15'b0, irq_o}, 16'h1);
    check("R2 read enabled", {15'b0, irq_o}, 16'h1);
    bus_wr(4'h1, 8'h5A);
  endtask

  task automatic t_set_wins;
    set_in(16'h8080);
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i); addr_i = 4'h1; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
    check("R4 set beats clear", {15'b0, irq_o}, 16'h1);
    bus_wr(4'h1, 8'h00);
    check("R4 later clear", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    set_in(16'hA53C); idle(3);
    bus_rd(4'h4, d);
    check("R8 low byte", {8'h0, d}, 16'h003C);
    bus_rd(4'h5, d);
    check("R8 high byte", {8'h0, d}, 16'h00A5);
    bus_rd(4'h9, d);
    check("R10 unused read", {8'h0, d}, 16'h0);
    bus_wr(4'h1, 8'h00);
    bus_wr(4'h2, 8'h00);
    set_in(16'h0000); idle(5);
    check("R2 write disabled", {15'b0, irq_o}, 16'h0);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_disabled_ignored();
    t_latency();
    t_hold_and_clear();
    t_disable_keep_status();
    t_set_wins();
    t_readback();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule